// File: doc/BRIEF.md
# E1 Time-Slot 16 Signaling Receiver

This block takes the time-slot 16 byte of each received E1 frame, one byte per frame, as a valid/ready stream. A plain flag from the upstream framer marks whether basic (TS0) frame alignment currently holds. The block runs its own 16-frame position counter and locks it to the channel-associated-signaling multiframe. It watches for the distant multiframe alarm and for signaling AIS. It pulls the three spare bits out of the frame-0 byte.

The signaling bytes of frames 0 to 15 are kept in a bank of sixteen byte-wide registers. A host reads them through a combinational read-address/read-data port. The bank only takes new values while both TS0 frame alignment and the block's own multiframe lock hold. When either is lost, the bank freezes, so downstream call-control logic never sees signaling from a misaligned stream.

Back-pressure rules: `in_ready` is high in every cycle after reset, and the block never stalls the stream. A byte is consumed in exactly those cycles where `in_valid` is high. Cycles with `in_valid` low change no state. Bits are numbered 1 to 8 with bit 1 the most significant bit of `in_byte` (the first bit on the line).

Top module: `cas_sig_rx`

## Requirements
- R1: `in_ready` is 1 in every cycle after reset. A cycle with `in_valid` low leaves every output and every bank register unchanged.
- R2: While unlocked, a byte whose upper nibble (bits 1-4) is 0000 declares lock in the next cycle. This needs `fas_ok` high and a previous consumed byte that was not 0x00. That byte is taken as frame 0, and the following bytes are frames 1, 2, … 15, 0, …
- R3: While locked, one frame-0 byte with a non-zero upper nibble is tolerated. A second consecutive one drops `mf_lock`.
- R4: While locked, the 16th consecutive 0x00 byte drops `mf_lock`. After that, no lock is declared until a non-zero byte has been consumed.
- R5: On a locked, correct frame-0 byte with `fas_ok` high, `xbits[0]` takes bit 5 (`in_byte[3]`), `xbits[1]` takes bit 7 (`in_byte[1]`), `xbits[2]` takes bit 8 (`in_byte[0]`), and `remote_alarm` takes bit 6 (`in_byte[2]`). No other byte changes them.
- R6: The zero bits are counted over each 16-byte window that ends on frame position 15. `sig_ais` becomes 1 after two consecutive windows with fewer than 3 zeros, and 0 after any window with 3 or more zeros. Declaring lock restarts the window at frame 0.
- R7: Reading `rd_addr` = k-1 returns register k, which is the last stored TS16 byte of frame k-1.
- R8: A byte is stored only when `fas_ok` is high, the block was locked, and the byte does not itself cause loss of lock. Otherwise the bank is left untouched.
- R9: After reset, `mf_lock`, `sig_ais`, `remote_alarm` and `xbits` are 0, and every bank register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A TS16 byte is present |
| in_ready | output | 1 | Always high after reset |
| in_byte | input | 8 | TS16 byte, bit 1 = MSB |
| fas_ok | input | 1 | Basic TS0 frame alignment holds |
| rd_addr | input | 4 | Bank read index (frame number) |
| rd_data | output | 8 | Bank register contents |
| mf_lock | output | 1 | Multiframe lock held |
| sig_ais | output | 1 | Signaling AIS detected |
| remote_alarm | output | 1 | Distant multiframe alarm bit |
| xbits | output | 3 | Spare bits X1 (bit 0) to X3 (bit 2) |

## Verification
The checker watches the stream rules on every cycle: ready stays high, idle cycles freeze lock, AIS, the spare bits and the read data, and lock rises only on a byte carrying the alignment nibble. Bank freezing while TS0 alignment is absent is also checked every cycle. The exact counting behaviour can only be shown by the bench's scenarios, which compare against a reference model. This covers tolerance of a single errored word, loss on the second word or on the sixteenth zero byte, AIS window boundaries, the bit positions of the spare bits, and which frame lands in which register.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] ts_byte_t;

  function automatic logic [3:0] zero_count(input ts_byte_t b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) n = n + {3'b000, ~b[i]};
    return n;
  endfunction
endpackage

// File: rtl/cas_mf_sync.sv
module cas_mf_sync
  import cas_pkg::*;
#(
  parameter int MF_LEN    = 16,
  parameter int LOSS_ERRS = 2,
  localparam int POS_W    = $clog2(MF_LEN),
  localparam int ERR_W    = $clog2(LOSS_ERRS + 1),
  localparam int ZR_W     = $clog2(MF_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  ts_byte_t         in_byte,
  input  logic             fas_ok,
  output logic             locked,
  output logic [POS_W-1:0] cur_pos,
  output logic             store_en,
  output logic             f0_update
);
  logic [POS_W-1:0] pos_q;
  logic [ERR_W-1:0] err_q;
  logic [ZR_W-1:0]  zrun_q, zrun_nxt;
  logic             prev_nz_q;
  logic             hunt_hit, mfas_bad, lose;

  always_comb begin
    hunt_hit = !locked && fas_ok && (in_byte[7:4] == 4'h0) && prev_nz_q;
    cur_pos  = hunt_hit ? '0 : pos_q;
    mfas_bad = locked && (pos_q == '0) && (in_byte[7:4] != 4'h0);
    if (in_byte != '0)
      zrun_nxt = '0;
    else if (zrun_q == ZR_W'(MF_LEN))
      zrun_nxt = zrun_q;
    else
      zrun_nxt = zrun_q + 1'b1;
    lose = locked && ((mfas_bad && (err_q == ERR_W'(LOSS_ERRS - 1)))
                      || (zrun_nxt == ZR_W'(MF_LEN)));
    store_en  = in_valid && fas_ok && locked && !lose;
    f0_update = store_en && (pos_q == '0) && !mfas_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      err_q     <= '0;
      zrun_q    <= '0;
      prev_nz_q <= 1'b0;
      locked    <= 1'b0;
    end else if (in_valid) begin
      pos_q     <= (cur_pos == POS_W'(MF_LEN - 1)) ? '0 : cur_pos + 1'b1;
      zrun_q    <= zrun_nxt;
      prev_nz_q <= (in_byte != '0);
      if (lose)          locked <= 1'b0;
      else if (hunt_hit) locked <= 1'b1;
      if (lose || hunt_hit)
        err_q <= '0;
      else if (locked && (pos_q == '0))
        err_q <= mfas_bad ? err_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/cas_ais_det.sv
module cas_ais_det
  import cas_pkg::*;
#(
  parameter int MF_LEN  = 16,
  parameter int AIS_MIN = 3,
  localparam int POS_W  = $clog2(MF_LEN),
  localparam int ACC_W  = $clog2(MF_LEN * BYTE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  ts_byte_t         in_byte,
  input  logic [POS_W-1:0] cur_pos,
  output logic             ais
);
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic             low_prev_q, low_now;

  always_comb begin
    acc_nxt = ((cur_pos == '0) ? '0 : acc_q) + ACC_W'(zero_count(in_byte));
    low_now = (acc_nxt < ACC_W'(AIS_MIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      low_prev_q <= 1'b0;
      ais        <= 1'b0;
    end else if (in_valid) begin
      acc_q <= acc_nxt;
      if (cur_pos == POS_W'(MF_LEN - 1)) begin
        ais        <= low_now && low_prev_q;
        low_prev_q <= low_now;
      end
    end
  end
endmodule

// File: rtl/cas_sig_bank.sv
module cas_sig_bank
  import cas_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int ADR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ADR_W-1:0] waddr,
  input  ts_byte_t         wdata,
  input  logic [ADR_W-1:0] raddr,
  output ts_byte_t         rdata
);
  ts_byte_t regs [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[k] <= '0;
      else if (we && (waddr == ADR_W'(k)))
        regs[k] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/cas_sig_rx.sv
module cas_sig_rx
  import cas_pkg::*;
#(
  parameter int MF_LEN    = 16,
  parameter int LOSS_ERRS = 2,
  parameter int AIS_MIN   = 3,
  localparam int POS_W    = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  input  logic             fas_ok,
  input  logic [POS_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic             mf_lock,
  output logic             sig_ais,
  output logic             remote_alarm,
  output logic [2:0]       xbits
);
  logic [POS_W-1:0] cur_pos;
  logic             store_en, f0_update;

  assign in_ready = rst_n;

  cas_mf_sync #(.MF_LEN(MF_LEN), .LOSS_ERRS(LOSS_ERRS)) u_sync (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .fas_ok(fas_ok), .locked(mf_lock), .cur_pos(cur_pos),
    .store_en(store_en), .f0_update(f0_update)
  );

  cas_ais_det #(.MF_LEN(MF_LEN), .AIS_MIN(AIS_MIN)) u_ais (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .cur_pos(cur_pos), .ais(sig_ais)
  );

  cas_sig_bank #(.DEPTH(MF_LEN)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(store_en), .waddr(cur_pos),
    .wdata(in_byte), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbits        <= '0;
      remote_alarm <= 1'b0;
    end else if (f0_update) begin
      xbits        <= {in_byte[0], in_byte[1], in_byte[3]};
      remote_alarm <= in_byte[2];
    end
  end
endmodule

// File: rtl/cas_sig_rx_chk.sv
module cas_sig_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_byte,
  input logic       fas_ok,
  input logic [3:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       mf_lock,
  input logic       sig_ais,
  input logic       remote_alarm,
  input logic [2:0] xbits
);
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) in_ready); // R1
  AST_IDLE_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(mf_lock)); // R1
  AST_LOCK_ON_MFAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_lock) |-> $past(in_valid && fas_ok && (in_byte[7:4] == 4'h0))); // R2
  AST_LOSS_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mf_lock) |-> $past(in_valid)); // R3
  AST_SPARE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && mf_lock && fas_ok) |=> ($stable(xbits) && $stable(remote_alarm))); // R5
  AST_AIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sig_ais)); // R6
  AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!fas_ok || !in_valid || !mf_lock) ##1 $stable(rd_addr) |-> $stable(rd_data)); // R8
endmodule

bind cas_sig_rx cas_sig_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_byte(in_byte), .fas_ok(fas_ok), .rd_addr(rd_addr), .rd_data(rd_data),
  .mf_lock(mf_lock), .sig_ais(sig_ais), .remote_alarm(remote_alarm),
  .xbits(xbits)
);

// File: tb/tb_cas_sig_rx.sv
module tb_cas_sig_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       fas_ok = 1'b0;
  logic [3:0] rd_addr = 4'h0;
  logic [7:0] rd_data;
  logic       mf_lock, sig_ais, remote_alarm;
  logic [2:0] xbits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  int m_pos, m_err, m_zrun, m_acc;
  bit m_lock, m_prevnz, m_lowprev, m_ais, m_rai;
  logic [2:0] m_x;
  logic [7:0] m_bank [16];

  always #10 clk = ~clk;

  cas_sig_rx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .fas_ok(fas_ok), .rd_addr(rd_addr), .rd_data(rd_data),
    .mf_lock(mf_lock), .sig_ais(sig_ais), .remote_alarm(remote_alarm),
    .xbits(xbits)
  );

  function automatic int zeros_of(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (!b[i]) n++;
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_pos = 0; m_err = 0; m_zrun = 0; m_acc = 0;
    m_lock = 0; m_prevnz = 0; m_lowprev = 0; m_ais = 0; m_rai = 0; m_x = 3'b000;
    for (int i = 0; i < 16; i++) m_bank[i] = 8'h00;
  endtask

  task automatic m_step(input logic [7:0] b, input bit f);
    int cp, zn, acc;
    bit hit, bad, lose, low;
    hit  = !m_lock && f && (b[7:4] == 4'h0) && m_prevnz;
    cp   = hit ? 0 : m_pos;
    bad  = m_lock && (m_pos == 0) && (b[7:4] != 4'h0);
    zn   = (b == 8'h00) ? ((m_zrun == 16) ? 16 : m_zrun + 1) : 0;
    lose = m_lock && ((bad && m_err == 1) || zn == 16);
    if (f && m_lock && !lose) begin
      m_bank[cp] = b;
      if (m_pos == 0 && !bad) begin
        m_x   = {b[0], b[1], b[3]};
        m_rai = b[2];
      end
    end
    acc = ((cp == 0) ? 0 : m_acc) + zeros_of(b);
    if (cp == 15) begin
      low = (acc < 3);
      m_ais = low && m_lowprev;
      m_lowprev = low;
    end
    m_acc = acc;
    if (lose || hit) m_err = 0;
    else if (m_lock && m_pos == 0) m_err = bad ? m_err + 1 : 0;
    m_lock   = lose ? 1'b0 : (hit ? 1'b1 : m_lock);
    m_pos    = (cp + 1) % 16;
    m_zrun   = zn;
    m_prevnz = (b != 8'h00);
  endtask

  task automatic cmp_outs();
    chk("R2", mf_lock, m_lock);
    chk("R6", sig_ais, m_ais);
    chk("R5", remote_alarm, m_rai);
    chk("R5", xbits, m_x);
  endtask

  task automatic send(input logic [7:0] b, input bit f);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; fas_ok = f;
    @(posedge clk);
    m_step(b, f);
    #5;
    in_valid = 1'b0;
    cmp_outs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_byte = 8'h00; fas_ok = 1'b1;
      @(posedge clk);
      #5;
      chk("R1", mf_lock, m_lock);
      chk("R1", sig_ais, m_ais);
    end
  endtask

  task automatic dump_bank(input string req);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      rd_addr = a[3:0];
      #1;
      chk(req, rd_data, m_bank[a]);
    end
  endtask

  // one multiframe: frame-0 byte given, others nonzero with nonzero upper nibble
  task automatic send_mf(input logic [7:0] f0, input bit f);
    send(f0, f);
    for (int k = 1; k < 16; k++) send(8'h10 + 8'(k) + 8'(($urandom % 14) << 4), f);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_reset();
    repeat (3) @(posedge clk);
    #5;
    // R9 reset state
    chk("R9", mf_lock, 0); chk("R9", sig_ais, 0);
    chk("R9", remote_alarm, 0); chk("R9", xbits, 0);
    @(negedge clk) rst_n = 1'b1;
    #5;
    chk("R1", in_ready, 1);
    dump_bank("R9");

    // R2: acquisition on first 0000 nibble after nonzero byte
    send(8'h55, 1'b1);
    chk("R2", mf_lock, 0);
    send(8'h0B, 1'b1);
    chk("R2", mf_lock, 1);
    for (int k = 1; k < 16; k++) send(8'h10 + 8'(k), 1'b1);
    // R5: X1 = bit5 (in_byte[3]), RAI = bit6 (in_byte[2]), X2/X3 = in_byte[1:0]
    send_mf(8'h04, 1'b1);
    chk("R5", remote_alarm, 1); chk("R5", xbits, 3'b000);
    send_mf(8'h0B, 1'b1);
    chk("R5", remote_alarm, 0); chk("R5", xbits, 3'b111);
    send_mf(8'h08, 1'b1);
    chk("R5", xbits, 3'b001);
    dump_bank("R7");
    idle(4);
    dump_bank("R1");

    // R8: bank frozen while TS0 alignment absent
    send_mf(8'h0F, 1'b0);
    dump_bank("R8");

    // R3: one errored word tolerated, second consecutive drops lock
    send_mf(8'h80, 1'b1);
    chk("R3", mf_lock, 1);
    send_mf(8'h0A, 1'b1);
    send(8'hC3, 1'b1);
    chk("R3", mf_lock, 1);
    for (int k = 1; k < 16; k++) send(8'h21, 1'b1);
    send(8'h91, 1'b1);
    chk("R3", mf_lock, 0);
    dump_bank("R8");

    // relock, then R4: 16 zero bytes
    send(8'h07, 1'b1);
    chk("R2", mf_lock, 1);
    send(8'h31, 1'b1);
    for (int k = 0; k < 15; k++) send(8'h00, 1'b1);
    chk("R4", mf_lock, 1);
    send(8'h00, 1'b1);
    chk("R4", mf_lock, 0);
    send(8'h00, 1'b1);
    chk("R4", mf_lock, 0);

    // R6: AIS on all-ones, clears after a window with enough zeros
    for (int k = 0; k < 48; k++) send(8'hFF, 1'b1);
    chk("R6", sig_ais, 1);
    for (int k = 0; k < 32; k++) send(8'hF1, 1'b1);
    chk("R6", sig_ais, 0);

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      int kind = $urandom % 4;
      bit f = ($urandom % 10) != 0;
      if (kind == 0) send_mf(8'($urandom % 16), f);
      else if (kind == 1) send(8'h00, f);
      else if (kind == 2) send(8'hFF, f);
      else send(8'($urandom), f);
    end
    dump_bank("R7");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule